// File: doc/BRIEF.md
# Indexed Operand Address Unit

This unit turns one indexed-mode selector byte, together with up to two trailing extension bytes, into the 16-bit address of an operand. The base is one of four 16-bit registers: X, Y, the stack pointer or the program counter. The offset can come from several sources: a short constant packed into the selector, a 9-bit or 16-bit signed constant taken from the extension bytes, or an accumulator. The selector can also ask for a signed step of 1 to 8 that rewrites the base register, either before or after the address is taken.

Two selector forms are indirect. For these the computed location holds a pointer. The unit fetches that 16-bit pointer one byte at a time, high byte first, and reports the pointer value as the final address.

The caller asserts `start` for one cycle while the selector, the extension bytes and the register values are valid, and must keep `start` low until `done` has pulsed. On the `done` pulse the unit also reports:
- how many extension bytes the selector used;
- whether the access was indirect;
- for stepping forms, the base register to write and its new value.

All address arithmetic wraps modulo 65536. When the program counter is the base, the caller supplies the address of the byte that follows the instruction, and the unit uses that value unchanged.

Top module: `idx_ea_unit`

## Requirements
- R1: After reset, `done`, `mem_rd`, `wb_en`, `indirect` and `illegal` are 0 and `ext_used` is 0.
- R2: For a selector with bit 5 = 0 and top bits not 111, the base is chosen by bits 7:6 (00 X, 01 Y, 10 SP, 11 PC). The address is the base plus bits 4:0 read as a signed value (−16..+15). `ext_used` = 0.
- R3: For a selector 111rr00s, the base is chosen by bits 4:3 using the same encoding. The offset is the 9-bit signed value {s, first extension byte}, giving −256..+255. `ext_used` = 1.
- R4: For a selector 111rr010, the offset is {first extension byte, second extension byte}. `ext_used` = 2.
- R5: For a selector 111rr1aa with aa ≠ 11, the offset is an accumulator. aa = 00 selects A zero-extended, aa = 01 selects B zero-extended, and aa = 10 selects D = {A, B}. `ext_used` = 0.
- R6: For a selector with bit 5 = 1 and top bits not 111, the base is chosen by bits 7:6. Bits 3:0 give a step: 0000..0111 mean +1..+8 and 1000..1111 mean −8..−1. The stepped base is written back: `wb_en` = 1, with `wb_sel` naming the register and `wb_val` holding the new value. When bit 4 = 0 the address is the stepped base; when bit 4 = 1 it is the old base.
- R7: A selector 111rr011 is indirect. The pointer location is the base plus {ext1, ext2}. The unit reads the byte at the pointer location and then the byte at the next address, and reports {first byte, second byte} as the address with `indirect` = 1 and `ext_used` = 2.
- R8: A selector 111rr111 is indirect, with the pointer location at the base plus D. The read order and result are the same as in R7, and `ext_used` = 0.
- R9: Every sum, step and pointer-byte address wraps modulo 65536.
- R10: Only R6 forms write back. A PC-based stepping form cannot be encoded, because top bits 111 always decode as the extended family. Across all 256 selectors `illegal` stays 0 and a write-back never names the PC (`wb_sel` 11).
- R11: `done` is a one-cycle pulse. It comes one cycle after `start` for direct forms and four cycles after `start` for indirect forms. Memory data is expected one cycle after the cycle in which `mem_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode using the present inputs |
| postbyte | input | 8 | Indexed-mode selector byte |
| ext_hi | input | 8 | First extension byte |
| ext_lo | input | 8 | Second extension byte |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Address of the byte after the instruction |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| mem_rdata | input | 8 | Byte returned one cycle after a read request |
| mem_rd | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte address |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective operand address |
| indirect | output | 1 | Address came from a fetched pointer |
| ext_used | output | 2 | Extension bytes consumed (0..2) |
| wb_en | output | 1 | Base register write-back request |
| wb_sel | output | 2 | Register to write (00 X, 01 Y, 10 SP, 11 PC) |
| wb_val | output | 16 | New base register value |
| illegal | output | 1 | Unencodable mode flag |

## Verification
The bench targets the step-field encoding, where 0000 must mean +1 and not 0. A decoder that reads the field as plain two's complement would leave the base unchanged and report an address one below the expected value. Pre- versus post-step is exercised on every base register, so a swapped bit 4 would report the stepped value where the old base is required. The 9-bit form is driven with the sign set and a zero extension byte, so that a sign taken from the wrong place would miss −256. Pointer fetches are placed at 0xFFFF, so that a wrong byte order or a missing wrap of the second read address would return a different word. A full sweep of all 256 selectors compares every output field against an independent model, which catches any family boundary that is decoded in the wrong order.

// File: rtl/idx_ea_unit.sv
module idx_ea_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    postbyte,
  input  logic [7:0]    ext_hi,
  input  logic [7:0]    ext_lo,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_sp,
  input  logic [AW-1:0] reg_pc,
  input  logic [AW/2-1:0] acc_a,
  input  logic [AW/2-1:0] acc_b,
  input  logic [7:0]    mem_rdata,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          indirect,
  output logic [1:0]    ext_used,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val,
  output logic          illegal
);
  localparam int HW = AW / 2;

  typedef enum logic [2:0] {S_IDLE, S_PHI, S_PLO, S_PWORD, S_DONE} st_t;
  st_t state;

  logic          is_ext, is_step;
  logic [1:0]    rr;
  logic [AW-1:0] base, off, step, stepped;
  logic [AW-1:0] d_ea;
  logic          d_ind, d_wb, d_ill;
  logic [1:0]    d_ext;
  logic [HW-1:0] ptr_hi;

  assign is_ext  = postbyte[7:5] == 3'b111;
  assign is_step = !is_ext && postbyte[5];
  assign rr      = is_ext ? postbyte[4:3] : postbyte[7:6];

  always_comb begin
    case (rr)
      2'b00:   base = reg_x;
      2'b01:   base = reg_y;
      2'b10:   base = reg_sp;
      default: base = reg_pc;
    endcase
  end

  assign step    = postbyte[3] ? {{(AW-4){1'b1}}, postbyte[3:0]}
                               : {{(AW-4){1'b0}}, postbyte[3:0]} + AW'(1);
  assign stepped = base + step;

  always_comb begin
    off   = '0;
    d_ind = 1'b0;
    d_ext = 2'd0;
    if (!is_ext) begin
      off = {{(AW-5){postbyte[4]}}, postbyte[4:0]};
    end else if (!postbyte[2]) begin
      case (postbyte[1:0])
        2'b00, 2'b01: begin off = {{(AW-8){postbyte[0]}}, ext_hi}; d_ext = 2'd1; end
        2'b10:        begin off = {ext_hi, ext_lo}; d_ext = 2'd2; end
        default:      begin off = {ext_hi, ext_lo}; d_ext = 2'd2; d_ind = 1'b1; end
      endcase
    end else begin
      case (postbyte[1:0])
        2'b00:   off = {{HW{1'b0}}, acc_a};
        2'b01:   off = {{HW{1'b0}}, acc_b};
        2'b10:   off = {acc_a, acc_b};
        default: begin off = {acc_a, acc_b}; d_ind = 1'b1; end
      endcase
    end
  end

  assign d_wb  = is_step && rr != 2'b11;
  assign d_ill = is_step && rr == 2'b11;
  assign d_ea  = is_step ? (postbyte[4] ? base : stepped) : base + off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ea       <= '0;
      indirect <= 1'b0;
      ext_used <= 2'd0;
      wb_en    <= 1'b0;
      wb_sel   <= 2'd0;
      wb_val   <= '0;
      illegal  <= 1'b0;
      ptr_hi   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ea       <= d_ea;
          indirect <= d_ind && !d_ill;
          ext_used <= d_ext;
          wb_en    <= d_wb;
          wb_sel   <= rr;
          wb_val   <= stepped;
          illegal  <= d_ill;
          state    <= (d_ind && !d_ill) ? S_PHI : S_DONE;
        end
        S_PHI:   state <= S_PLO;
        S_PLO:   begin ptr_hi <= mem_rdata; state <= S_PWORD; end
        S_PWORD: begin ea <= {ptr_hi, mem_rdata}; state <= S_DONE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_rd   = state == S_PHI || state == S_PLO;
  assign mem_addr = (state == S_PLO) ? ea + AW'(1) : ea;
  assign done     = state == S_DONE;
endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          indirect,
  input logic [1:0]    ext_used,
  input logic          wb_en,
  input logic [1:0]    wb_sel,
  input logic          illegal
);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_rd_next_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !$past(mem_rd)) |=> (mem_rd && mem_addr == $past(mem_addr) + AW'(1)));

  p_rd_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |=> !mem_rd);

  p_no_pc_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wb_en) |-> (wb_sel != 2'b11 && !illegal));

  p_step_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wb_en) |-> (!indirect && ext_used == 2'd0));

  p_ext_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ext_used != 2'd3);

  p_rd_not_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !done);
endmodule

bind idx_ea_unit idx_ea_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_idx_ea_unit.sv
module tb_idx_ea_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0]  postbyte = '0, ext_hi = '0, ext_lo = '0, acc_a = '0, acc_b = '0;
  logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
  logic [7:0]  mem_rdata = '0;
  logic        mem_rd, done, indirect, wb_en, illegal;
  logic [15:0] mem_addr, ea, wb_val;
  logic [1:0]  ext_used, wb_sel;

  int checks = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ea_unit dut (.*);

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  typedef struct packed {
    logic [15:0] ea;
    logic        ind;
    logic [1:0]  ext;
    logic        wb;
    logic [1:0]  sel;
    logic [15:0] val;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];

  function automatic logic [15:0] pick(input logic [1:0] r);
    return r == 2'd0 ? reg_x : r == 2'd1 ? reg_y : r == 2'd2 ? reg_sp : reg_pc;
  endfunction

  function automatic exp_t model(input logic [7:0] pb, eh, el);
    exp_t e = '0;
    logic [15:0] b, p;
    int s;
    b = pick(pb[4:3]);
    casez (pb)
      8'b111??00?: begin e.ea = b + (pb[0] ? 16'(eh) - 16'd256 : 16'(eh)); e.ext = 1; end
      8'b111??010: begin e.ea = b + {eh, el}; e.ext = 2; end
      8'b111??011: begin p = b + {eh, el}; e.ea = {memf(p), memf(p + 16'd1)}; e.ind = 1; e.ext = 2; end
      8'b111??100: e.ea = b + 16'(acc_a);
      8'b111??101: e.ea = b + 16'(acc_b);
      8'b111??110: e.ea = b + {acc_a, acc_b};
      8'b111??111: begin p = b + {acc_a, acc_b}; e.ea = {memf(p), memf(p + 16'd1)}; e.ind = 1; end
      8'b??0?????: begin
        b = pick(pb[7:6]);
        s = pb[4] ? int'(pb[3:0]) - 16 : int'(pb[3:0]);
        e.ea = b + 16'(s);
      end
      default: begin
        b = pick(pb[7:6]);
        s = pb[3] ? int'(pb[3:0]) - 16 : int'(pb[3:0]) + 1;
        e.wb = 1; e.sel = pb[7:6]; e.val = b + 16'(s);
        e.ea = pb[4] ? b : e.val;
      end
    endcase
    return e;
  endfunction

  task automatic run(input logic [7:0] pb, eh, el, input string tag);
    exp_t e;
    int lat;
    e = model(pb, eh, el);
    expq.push_back(e);
    tagq.push_back(tag);
    @(negedge clk);
    postbyte = pb; ext_hi = eh; ext_lo = el; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    checks++;
    if (lat != (e.ind ? 4 : 1)) begin
      bad++;
      $display("FAIL %s R11 latency pb=%h act=%0d exp=%0d", tag, pb, lat, e.ind ? 4 : 1);
    end
  endtask

  always @(negedge clk) if (done && rst_n) begin
    exp_t e;
    string t;
    if (expq.size() == 0) begin
      checks++; bad++;
      $display("FAIL R11 unexpected done act=1 exp=0");
    end else begin
      e = expq.pop_front();
      t = tagq.pop_front();
      checks++;
      if (ea !== e.ea || indirect !== e.ind || ext_used !== e.ext || wb_en !== e.wb ||
          illegal !== 1'b0 || (e.wb && (wb_sel !== e.sel || wb_val !== e.val))) begin
        bad++;
        $display("FAIL %s pb=%h act ea=%h ind=%b ext=%0d wb=%b sel=%0d val=%h ill=%b exp ea=%h ind=%b ext=%0d wb=%b sel=%0d val=%h ill=0",
                 t, postbyte, ea, indirect, ext_used, wb_en, wb_sel, wb_val, illegal,
                 e.ea, e.ind, e.ext, e.wb, e.sel, e.val);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 0 || mem_rd !== 0 || wb_en !== 0 || indirect !== 0 || illegal !== 0 || ext_used !== 0) begin
      bad++;
      $display("FAIL R1 reset act=%b%b%b%b%b%0d exp=000000", done, mem_rd, wb_en, indirect, illegal, ext_used);
    end
    rst_n = 1'b1;
    reg_x = 16'h1000; reg_y = 16'h2000; reg_sp = 16'h3C00; reg_pc = 16'h4002;
    acc_a = 8'h80; acc_b = 8'hF1;

    run(8'b000_01111, 0, 0, "R2 X+15");
    run(8'b100_10000, 0, 0, "R2 SP-16");
    run(8'b110_00011, 0, 0, "R2 PC+3");
    run(8'b111_01_000, 8'hFF, 0, "R3 Y+255");
    run(8'b111_00_001, 8'h00, 0, "R3 X-256");
    run(8'b111_10_010, 8'h12, 8'h34, "R4 SP+1234");
    run(8'b111_00_100, 0, 0, "R5 A zero-ext");
    run(8'b111_01_101, 0, 0, "R5 B zero-ext");
    run(8'b111_11_110, 0, 0, "R5 D");
    run(8'b01_1_0_0111, 0, 0, "R6 pre +8 Y");
    run(8'b00_1_1_1111, 0, 0, "R6 post -1 X");
    run(8'b10_1_0_1000, 0, 0, "R6 pre -8 SP");
    run(8'b00_1_1_0000, 0, 0, "R6 post +1 X");
    run(8'b111_01_011, 8'h00, 8'h40, "R7 indirect 16");
    run(8'b111_10_111, 0, 0, "R8 D indirect");

    reg_x = 16'hFFF0; reg_y = 16'hFFFC; reg_sp = 16'h0003;
    run(8'b111_00_010, 8'h00, 8'h20, "R9 wrap sum");
    run(8'b01_1_0_0111, 0, 0, "R9 wrap step up");
    run(8'b10_1_1_1000, 0, 0, "R9 wrap step down");
    run(8'b111_00_011, 8'h00, 8'h0F, "R9 pointer at FFFF");
    acc_a = 8'h00; acc_b = 8'h0F;
    run(8'b111_00_111, 0, 0, "R9 D pointer at FFFF");

    reg_x = 16'h1357; reg_y = 16'h8642; reg_sp = 16'hA0A0; reg_pc = 16'h7FFE;
    acc_a = 8'h9C; acc_b = 8'h3B;
    for (int i = 0; i < 256; i++) run(8'(i), 8'h3C, 8'hC3, "R10 sweep");

    repeat (3) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL R11 missing done act=%0d exp=0", expq.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule